// File: doc/BRIEF.md
# Outstanding Memory Request Slot Table

This block keeps a small, fixed set of slots that track memory requests in flight from a pipeline running several hardware threads. Each slot records the owning thread, the instruction's sequence number, a schedule index, a command code and four state flags: access pending, access complete, squashed, and stalled on address translation. Every request from a pipeline stage claims a slot. Later stages find their slot again by matching thread, sequence number and schedule index.

The table also holds translation-fault state for each thread. A fault reported against a slot blocks that thread from claiming new slots until a trap-clear arrives, or until a squash removes the faulting instruction. Squash broadcasts name a thread and a sequence-number boundary. Younger slots of that thread are marked squashed. A squashed slot with no access in flight is released at once. A squashed slot whose access is still in flight stays until its response comes back, and that response is then discarded.

Top module: `mem_slot_table`

## Requirements
- R1: A lookup hits only a busy slot whose thread, sequence number and schedule index all equal the lookup inputs. On a hit it reports the lowest such slot index and that slot's command, pending, complete and squashed flags.
- R2: An allocation request is granted in the same cycle to the lowest-index free slot, which reads as busy from the next cycle. `table_full` is high exactly when every slot is busy, and no grant is given then. `alloc_issue` = 1 marks the new slot pending.
- R3: A fault reported against a busy, non-squashed, non-pending slot blocks that slot's thread from the next cycle and records the slot's sequence number. Allocation requests from a blocked thread are refused. A fault against a free, squashed or pending slot has no effect.
- R4: A trap-clear for a thread clears that thread's blocked flag at the next clock edge.
- R5: A squash of thread T with boundary S marks as squashed every busy, not yet squashed slot of T whose sequence number is strictly greater than S. When `sq_stall` = 1 the boundary is S+1. Sequence numbers compare as unsigned values with no wrap.
- R6: A squash releases its thread's block only when the recorded blocking sequence number is greater than the boundary.
- R7: A newly squashed slot with no pending access becomes free at the next edge. A squashed pending slot stays busy and reads as squashed until its response arrives. That response raises `rsp_drop` and frees the slot.
- R8: Squashing a slot that is stalled on translation clears its stall and its thread's block at the next edge. The slot itself is freed one cycle later.
- R9: A response to a pending, non-squashed slot raises `rsp_ok`, clears pending and sets complete. A response to a slot that is not pending has no effect.
- R10: A squash and an allocation in the same cycle are resolved squash first. A block the squash releases does not refuse the allocation. The new slot is never squashed by that squash. Slots freed by the squash can be allocated only from the next cycle.
- R11: A lookup with `lkp_retire` = 1 that hits frees the hit slot at the next edge.
- R12: After reset every slot is free, no thread is blocked, and the grant, hit and response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Request a new slot |
| alloc_tid | input | TID_W | Requesting thread |
| alloc_seq | input | SEQ_W | Sequence number of the instruction |
| alloc_idx | input | IDX_W | Schedule index |
| alloc_cmd | input | CMD_W | Command code |
| alloc_issue | input | 1 | Access is issued with the allocation (slot starts pending) |
| alloc_gnt | output | 1 | Allocation granted this cycle |
| alloc_slot | output | SLOT_W | Slot granted |
| table_full | output | 1 | Every slot busy |
| lkp_tid | input | TID_W | Lookup thread |
| lkp_seq | input | SEQ_W | Lookup sequence number |
| lkp_idx | input | IDX_W | Lookup schedule index |
| lkp_retire | input | 1 | Free the hit slot |
| lkp_hit | output | 1 | Lookup matched a slot |
| lkp_slot | output | SLOT_W | Matching slot |
| lkp_cmd | output | CMD_W | Command of matching slot |
| lkp_pend | output | 1 | Matching slot has an access pending |
| lkp_done | output | 1 | Matching slot access complete |
| lkp_sqd | output | 1 | Matching slot squashed |
| rsp_valid | input | 1 | Memory response arrives |
| rsp_slot | input | SLOT_W | Slot the response belongs to |
| rsp_ok | output | 1 | Response accepted as completion |
| rsp_drop | output | 1 | Response discarded for a squashed slot |
| flt_valid | input | 1 | Translation fault report |
| flt_slot | input | SLOT_W | Slot that faulted |
| trap_valid | input | 1 | Fault handled for a thread |
| trap_tid | input | TID_W | Thread whose block is cleared |
| sq_valid | input | 1 | Squash broadcast |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Sequence boundary |
| sq_stall | input | 1 | Squash caused by a memory stall (boundary + 1) |
| thr_blocked | output | NUM_THREADS | Per-thread translation block |
| slot_busy | output | NUM_SLOTS | Per-slot busy flag |

## Verification
The assertions assume that NUM_SLOTS is a power of two, so that every slot-index input names a real slot. They also assume that a trap-clear and a fault report never both drive the same cycle when the trap check applies, so the label on that property excludes fault cycles. The stimulus therefore draws slot indices only from the legal range, and directed sequences reach the corner cases: a squash on a translation-stalled slot, a squash on a pending slot followed by its response, and a squash that frees a block in the same cycle as an allocation. A constrained random phase then mixes all ports freely over a narrow range of sequence numbers so that lookups and squashes hit often.

// File: rtl/mst_pkg.sv
// Shared types of the memory request slot table.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package mst_pkg;

    // Per-slot state flags kept alongside the identity fields.
    typedef struct packed {
        logic pend;    // memory access in flight
        logic done;    // memory access completed
        logic sqd;     // slot was squashed
        logic tstall;  // stalled on address translation
    } slot_flags_t;

endpackage

// File: rtl/mst_first_free.sv
// Lowest-index free slot finder.
// Assumes busy[i] = 1 marks slot i occupied; idx is 0 when none is free.
module mst_first_free #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] busy,
    output logic         found,
    output logic [W-1:0] idx
);

    // Scan from the top so the lowest free index is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end

endmodule

// File: rtl/mst_match.sv
// Associative lookup over slot identity fields.
// Assumes the caller presents valid bits and per-slot tags; lowest match wins.
module mst_match #(
    parameter int N     = 4,
    parameter int W     = 2,
    parameter int TID_W = 1,
    parameter int SEQ_W = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vld,
    input  logic [TID_W-1:0] tid  [N],
    input  logic [SEQ_W-1:0] seq  [N],
    input  logic [IDX_W-1:0] sidx [N],
    input  logic [TID_W-1:0] q_tid,
    input  logic [SEQ_W-1:0] q_seq,
    input  logic [IDX_W-1:0] q_idx,
    output logic             hit,
    output logic [W-1:0]     slot
);

    logic [N-1:0] eq;

    // Per-slot tag comparison.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign eq[i] = vld[i] && (tid[i] == q_tid) && (seq[i] == q_seq)
                       && (sidx[i] == q_idx);
    end

    // Priority pick of the lowest matching index.
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit  = 1'b1;
                slot = W'(i);
            end
        end
    end

endmodule

// File: rtl/mst_block.sv
// Per-thread translation-fault block register with recorded sequence number.
// Assumes bound is the squash boundary already widened by one bit.
module mst_block #(
    parameter int NT    = 2,
    parameter int TID_W = 1,
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sq_valid,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W:0]   bound,
    input  logic [NT-1:0]    stall_clr,
    input  logic             trap_valid,
    input  logic [TID_W-1:0] trap_tid,
    input  logic             set_valid,
    input  logic [TID_W-1:0] set_tid,
    input  logic [SEQ_W-1:0] set_seq,
    output logic [NT-1:0]    blocked_q,
    output logic [NT-1:0]    blocked_eff
);

    logic [SEQ_W-1:0] bseq_q [NT];
    logic [NT-1:0]    rel;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        // Squash releases the block only when the faulting instruction is younger.
        assign rel[t] = sq_valid && (sq_tid == TID_W'(t)) && blocked_q[t]
                        && ({1'b0, bseq_q[t]} > bound);

        // Block state seen by same-cycle allocation, after the squash.
        assign blocked_eff[t] = blocked_q[t] && !rel[t] && !stall_clr[t];

        // Fault sets the block; squash and trap clear it; a fault wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                blocked_q[t] <= 1'b0;
                bseq_q[t]    <= '0;
            end else if (set_valid && (set_tid == TID_W'(t))) begin
                blocked_q[t] <= 1'b1;
                bseq_q[t]    <= set_seq;
            end else if (rel[t] || stall_clr[t]
                         || (trap_valid && (trap_tid == TID_W'(t)))) begin
                blocked_q[t] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mem_slot_table.sv
// Table of outstanding memory request slots shared by hardware threads.
// Allocates, looks up, completes, squashes and frees slots; keeps per-thread
// translation blocks. Assumes NUM_SLOTS is a power of two and NUM_THREADS >= 2.
// Within a cycle the squash is applied first, then response, retire, fault.
module mem_slot_table #(
    parameter int NUM_SLOTS   = 4,
    parameter int NUM_THREADS = 2,
    parameter int SEQ_W       = 8,
    parameter int IDX_W       = 3,
    parameter int CMD_W       = 2,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_req,
    input  logic [TID_W-1:0]       alloc_tid,
    input  logic [SEQ_W-1:0]       alloc_seq,
    input  logic [IDX_W-1:0]       alloc_idx,
    input  logic [CMD_W-1:0]       alloc_cmd,
    input  logic                   alloc_issue,
    output logic                   alloc_gnt,
    output logic [SLOT_W-1:0]      alloc_slot,
    output logic                   table_full,
    input  logic [TID_W-1:0]       lkp_tid,
    input  logic [SEQ_W-1:0]       lkp_seq,
    input  logic [IDX_W-1:0]       lkp_idx,
    input  logic                   lkp_retire,
    output logic                   lkp_hit,
    output logic [SLOT_W-1:0]      lkp_slot,
    output logic [CMD_W-1:0]       lkp_cmd,
    output logic                   lkp_pend,
    output logic                   lkp_done,
    output logic                   lkp_sqd,
    input  logic                   rsp_valid,
    input  logic [SLOT_W-1:0]      rsp_slot,
    output logic                   rsp_ok,
    output logic                   rsp_drop,
    input  logic                   flt_valid,
    input  logic [SLOT_W-1:0]      flt_slot,
    input  logic                   trap_valid,
    input  logic [TID_W-1:0]       trap_tid,
    input  logic                   sq_valid,
    input  logic [TID_W-1:0]       sq_tid,
    input  logic [SEQ_W-1:0]       sq_seq,
    input  logic                   sq_stall,
    output logic [NUM_THREADS-1:0] thr_blocked,
    output logic [NUM_SLOTS-1:0]   slot_busy
);

    import mst_pkg::*;

    localparam int BND_W = SEQ_W + 1;

    // Slot storage.
    logic [NUM_SLOTS-1:0] vld_q;
    slot_flags_t          fl_q   [NUM_SLOTS];
    logic [TID_W-1:0]     tid_q  [NUM_SLOTS];
    logic [SEQ_W-1:0]     seq_q  [NUM_SLOTS];
    logic [IDX_W-1:0]     idx_q  [NUM_SLOTS];
    logic [CMD_W-1:0]     cmd_q  [NUM_SLOTS];

    // Per-cycle decode.
    logic [BND_W-1:0]       bound;
    logic [NUM_SLOTS-1:0]   kill;
    logic [NUM_SLOTS-1:0]   sqd_eff;
    logic [NUM_SLOTS-1:0]   rsp_sel;
    logic [NUM_SLOTS-1:0]   ret_sel;
    logic [NUM_SLOTS-1:0]   flt_sel;
    logic [NUM_THREADS-1:0] stall_clr;
    logic [NUM_THREADS-1:0] blk_eff;
    logic                   free_found;
    logic [SLOT_W-1:0]      free_idx;
    logic                   flt_ok;
    logic                   rsp_hit;

    // Squash boundary: S, or S+1 for a stall-caused squash.
    assign bound = {1'b0, sq_seq} + BND_W'(sq_stall);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dec
        // Slot killed by this cycle's squash.
        assign kill[i]    = sq_valid && vld_q[i] && !fl_q[i].sqd
                            && (tid_q[i] == sq_tid)
                            && ({1'b0, seq_q[i]} > bound);
        assign sqd_eff[i] = fl_q[i].sqd || kill[i];
        assign rsp_sel[i] = rsp_hit && (rsp_slot == SLOT_W'(i));
        assign ret_sel[i] = lkp_retire && lkp_hit && (lkp_slot == SLOT_W'(i));
        assign flt_sel[i] = flt_ok && (flt_slot == SLOT_W'(i));
    end

    // Threads whose translation-stalled slot is squashed this cycle.
    always_comb begin
        stall_clr = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (kill[i] && fl_q[i].tstall) begin
                stall_clr[tid_q[i]] = 1'b1;
            end
        end
    end

    // Fault qualification against the addressed slot.
    assign flt_ok = flt_valid && vld_q[flt_slot] && !sqd_eff[flt_slot]
                    && !fl_q[flt_slot].pend;

    // Response classification.
    assign rsp_hit  = rsp_valid && vld_q[rsp_slot] && fl_q[rsp_slot].pend;
    assign rsp_ok   = rsp_hit && !sqd_eff[rsp_slot];
    assign rsp_drop = rsp_hit && sqd_eff[rsp_slot];

    mst_first_free #(
        .N (NUM_SLOTS),
        .W (SLOT_W)
    ) u_free (
        .busy  (vld_q),
        .found (free_found),
        .idx   (free_idx)
    );

    mst_match #(
        .N     (NUM_SLOTS),
        .W     (SLOT_W),
        .TID_W (TID_W),
        .SEQ_W (SEQ_W),
        .IDX_W (IDX_W)
    ) u_match (
        .vld   (vld_q),
        .tid   (tid_q),
        .seq   (seq_q),
        .sidx  (idx_q),
        .q_tid (lkp_tid),
        .q_seq (lkp_seq),
        .q_idx (lkp_idx),
        .hit   (lkp_hit),
        .slot  (lkp_slot)
    );

    mst_block #(
        .NT    (NUM_THREADS),
        .TID_W (TID_W),
        .SEQ_W (SEQ_W)
    ) u_block (
        .clk         (clk),
        .rst_n       (rst_n),
        .sq_valid    (sq_valid),
        .sq_tid      (sq_tid),
        .bound       (bound),
        .stall_clr   (stall_clr),
        .trap_valid  (trap_valid),
        .trap_tid    (trap_tid),
        .set_valid   (flt_ok),
        .set_tid     (tid_q[flt_slot]),
        .set_seq     (seq_q[flt_slot]),
        .blocked_q   (thr_blocked),
        .blocked_eff (blk_eff)
    );

    // Allocation decision uses post-squash block state and registered busy bits.
    assign alloc_gnt  = alloc_req && free_found && !blk_eff[alloc_tid];
    assign alloc_slot = free_idx;
    assign table_full = &vld_q;
    assign slot_busy  = vld_q;

    // Lookup result fields from the hit slot.
    assign lkp_cmd  = lkp_hit ? cmd_q[lkp_slot]      : '0;
    assign lkp_pend = lkp_hit && fl_q[lkp_slot].pend;
    assign lkp_done = lkp_hit && fl_q[lkp_slot].done;
    assign lkp_sqd  = lkp_hit && fl_q[lkp_slot].sqd;

    // Slot state update in squash, response, retire, fault, allocate order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                fl_q[i]  <= '0;
                tid_q[i] <= '0;
                seq_q[i] <= '0;
                idx_q[i] <= '0;
                cmd_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (vld_q[i]) begin
                    if (kill[i] && fl_q[i].tstall) begin
                        fl_q[i].sqd    <= 1'b1;
                        fl_q[i].tstall <= 1'b0;
                    end else if (sqd_eff[i] && !fl_q[i].pend) begin
                        vld_q[i] <= 1'b0;
                        fl_q[i]  <= '0;
                    end else begin
                        if (kill[i]) begin
                            fl_q[i].sqd <= 1'b1;
                        end
                        if (rsp_sel[i]) begin
                            if (sqd_eff[i]) begin
                                vld_q[i] <= 1'b0;
                                fl_q[i]  <= '0;
                            end else begin
                                fl_q[i].pend <= 1'b0;
                                fl_q[i].done <= 1'b1;
                            end
                        end else if (ret_sel[i]) begin
                            vld_q[i] <= 1'b0;
                            fl_q[i]  <= '0;
                        end else if (flt_sel[i]) begin
                            fl_q[i].tstall <= 1'b1;
                        end
                    end
                end else if (alloc_gnt && (alloc_slot == SLOT_W'(i))) begin
                    vld_q[i]       <= 1'b1;
                    tid_q[i]       <= alloc_tid;
                    seq_q[i]       <= alloc_seq;
                    idx_q[i]       <= alloc_idx;
                    cmd_q[i]       <= alloc_cmd;
                    fl_q[i].pend   <= alloc_issue;
                    fl_q[i].done   <= 1'b0;
                    fl_q[i].sqd    <= 1'b0;
                    fl_q[i].tstall <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/mst_chk.sv
// Temporal checks on the slot table ports, bound to every instance.
// Assumes synchronous active-low reset held at time zero.
module mst_chk #(
    parameter int NUM_SLOTS   = 4,
    parameter int NUM_THREADS = 2,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   alloc_req,
    input logic [TID_W-1:0]       alloc_tid,
    input logic                   alloc_gnt,
    input logic [SLOT_W-1:0]      alloc_slot,
    input logic                   table_full,
    input logic                   lkp_hit,
    input logic [SLOT_W-1:0]      lkp_slot,
    input logic                   rsp_ok,
    input logic                   rsp_drop,
    input logic [SLOT_W-1:0]      rsp_slot,
    input logic                   flt_valid,
    input logic                   trap_valid,
    input logic [TID_W-1:0]       trap_tid,
    input logic                   sq_valid,
    input logic [NUM_THREADS-1:0] thr_blocked,
    input logic [NUM_SLOTS-1:0]   slot_busy
);

    // R2
    alloc_takes_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |=> slot_busy[$past(alloc_slot)]);

    // R2
    full_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        table_full |-> !alloc_gnt);

    // R3
    blocked_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && thr_blocked[alloc_tid] && !sq_valid) |-> !alloc_gnt);

    // R4
    trap_unblocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !flt_valid) |=> !thr_blocked[$past(trap_tid)]);

    // R7
    drop_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_drop |=> !slot_busy[$past(rsp_slot)]);

    // R9
    rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ok && rsp_drop));

    // R1
    hit_on_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_hit |-> slot_busy[lkp_slot]);

endmodule

bind mem_slot_table mst_chk #(
    .NUM_SLOTS   (NUM_SLOTS),
    .NUM_THREADS (NUM_THREADS)
) u_chk (.*);

// File: tb/tb_mem_slot_table.sv
// Self-checking bench: behavioural reference model compared every cycle.
module tb_mem_slot_table;

    localparam int NS = 4;
    localparam int NT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req = 0, alloc_issue = 0;
    logic [0:0] alloc_tid = 0;
    logic [7:0] alloc_seq = 0;
    logic [2:0] alloc_idx = 0;
    logic [1:0] alloc_cmd = 0;
    logic       alloc_gnt, table_full;
    logic [1:0] alloc_slot;
    logic [0:0] lkp_tid = 0;
    logic [7:0] lkp_seq = 0;
    logic [2:0] lkp_idx = 0;
    logic       lkp_retire = 0;
    logic       lkp_hit, lkp_pend, lkp_done, lkp_sqd;
    logic [1:0] lkp_slot, lkp_cmd;
    logic       rsp_valid = 0;
    logic [1:0] rsp_slot = 0;
    logic       rsp_ok, rsp_drop;
    logic       flt_valid = 0;
    logic [1:0] flt_slot = 0;
    logic       trap_valid = 0;
    logic [0:0] trap_tid = 0;
    logic       sq_valid = 0, sq_stall = 0;
    logic [0:0] sq_tid = 0;
    logic [7:0] sq_seq = 0;
    logic [NT-1:0] thr_blocked;
    logic [NS-1:0] slot_busy;

    always #2 clk = ~clk;

    mem_slot_table #(.NUM_SLOTS(NS), .NUM_THREADS(NT), .SEQ_W(8), .IDX_W(3), .CMD_W(2)) dut (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Reference model state.
    bit mv[NS], mp[NS], md[NS], ms[NS], mt[NS];
    int mtid[NS], mseq[NS], midx[NS], mcmd[NS];
    bit mblk[NT];
    int mbseq[NT];

    task automatic chk(string tag, string nm, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, nm, got, exp);
        end
    endtask

    task automatic clear_inputs();
        alloc_req = 0; alloc_issue = 0; lkp_retire = 0; rsp_valid = 0;
        flt_valid = 0; trap_valid = 0; sq_valid = 0; sq_stall = 0;
    endtask

    // One cycle: compare outputs with the model, advance model, clock.
    task automatic step(string tag);
        bit kill[NS], s2[NS], sclr[NT], rel[NT], eff[NT];
        bit nv[NS], np[NS], nd[NS], ns_[NS], nt[NS], nb[NT];
        int nbs[NT];
        int bnd, ff, lh, ls, hit_ok, egnt, rsel, fok, fs;
        bit eok, edrop;
        #1;
        bnd = int'(sq_seq) + int'(sq_stall);
        foreach (sclr[t]) sclr[t] = 0;
        for (int i = 0; i < NS; i++) begin
            kill[i] = sq_valid && mv[i] && !ms[i] && mtid[i] == int'(sq_tid) && mseq[i] > bnd;
            s2[i] = ms[i] || kill[i];
            if (kill[i] && mt[i]) sclr[mtid[i]] = 1;
        end
        for (int t = 0; t < NT; t++) begin
            rel[t] = sq_valid && int'(sq_tid) == t && mblk[t] && mbseq[t] > bnd;
            eff[t] = mblk[t] && !rel[t] && !sclr[t];
        end
        ff = -1;
        for (int i = NS - 1; i >= 0; i--) if (!mv[i]) ff = i;
        egnt = alloc_req && ff >= 0 && !eff[alloc_tid];
        lh = 0; ls = 0;
        for (int i = NS - 1; i >= 0; i--)
            if (mv[i] && mtid[i] == int'(lkp_tid) && mseq[i] == int'(lkp_seq) && midx[i] == int'(lkp_idx)) begin
                lh = 1; ls = i;
            end
        rsel = rsp_valid && mv[rsp_slot] && mp[rsp_slot];
        eok = rsel && !s2[rsp_slot];
        edrop = rsel && s2[rsp_slot];
        fs = int'(flt_slot);
        fok = flt_valid && mv[fs] && !s2[fs] && !mp[fs];

        chk(tag, "alloc_gnt R2", alloc_gnt, egnt);
        if (egnt) chk(tag, "alloc_slot R2", alloc_slot, ff);
        chk(tag, "table_full R2", table_full, ff < 0);
        chk(tag, "lkp_hit R1", lkp_hit, lh);
        if (lh) begin
            chk(tag, "lkp_slot R1", lkp_slot, ls);
            chk(tag, "lkp_cmd R1", lkp_cmd, mcmd[ls]);
            chk(tag, "lkp_pend R1", lkp_pend, mp[ls]);
            chk(tag, "lkp_done R9", lkp_done, md[ls]);
            chk(tag, "lkp_sqd R7", lkp_sqd, ms[ls]);
        end
        chk(tag, "rsp_ok R9", rsp_ok, eok);
        chk(tag, "rsp_drop R7", rsp_drop, edrop);
        for (int t = 0; t < NT; t++) chk(tag, "thr_blocked R3", thr_blocked[t], mblk[t]);
        for (int i = 0; i < NS; i++) chk(tag, "slot_busy R7", slot_busy[i], mv[i]);

        // Next state.
        for (int i = 0; i < NS; i++) begin
            nv[i] = mv[i]; np[i] = mp[i]; nd[i] = md[i]; ns_[i] = ms[i]; nt[i] = mt[i];
            if (mv[i]) begin
                if (kill[i] && mt[i]) begin ns_[i] = 1; nt[i] = 0; end
                else if (s2[i] && !mp[i]) begin nv[i] = 0; np[i] = 0; nd[i] = 0; ns_[i] = 0; nt[i] = 0; end
                else begin
                    if (kill[i]) ns_[i] = 1;
                    if (rsel && int'(rsp_slot) == i) begin
                        if (s2[i]) begin nv[i] = 0; np[i] = 0; nd[i] = 0; ns_[i] = 0; nt[i] = 0; end
                        else begin np[i] = 0; nd[i] = 1; end
                    end else if (lkp_retire && lh && ls == i) begin
                        nv[i] = 0; np[i] = 0; nd[i] = 0; ns_[i] = 0; nt[i] = 0;
                    end else if (fok && fs == i) nt[i] = 1;
                end
            end else if (egnt && ff == i) begin
                nv[i] = 1; np[i] = alloc_issue; nd[i] = 0; ns_[i] = 0; nt[i] = 0;
                mtid[i] = int'(alloc_tid); mseq[i] = int'(alloc_seq);
                midx[i] = int'(alloc_idx); mcmd[i] = int'(alloc_cmd);
            end
        end
        for (int t = 0; t < NT; t++) begin
            nb[t] = mblk[t]; nbs[t] = mbseq[t];
            if (fok && mtid[fs] == t) begin nb[t] = 1; nbs[t] = mseq[fs]; end
            else if (rel[t] || sclr[t] || (trap_valid && int'(trap_tid) == t)) nb[t] = 0;
        end
        @(posedge clk);
        mv = nv; mp = np; md = nd; ms = ns_; mt = nt; mblk = nb; mbseq = nbs;
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic do_alloc(int tid, int seq, int idx, int cmd, bit iss);
        alloc_req = 1; alloc_tid = 1'(tid); alloc_seq = 8'(seq);
        alloc_idx = 3'(idx); alloc_cmd = 2'(cmd); alloc_issue = iss;
    endtask

    task automatic do_lkp(int tid, int seq, int idx, bit ret);
        lkp_tid = 1'(tid); lkp_seq = 8'(seq); lkp_idx = 3'(idx); lkp_retire = ret;
    endtask

    task automatic do_sq(int tid, int seq, bit stl);
        sq_valid = 1; sq_tid = 1'(tid); sq_seq = 8'(seq); sq_stall = stl;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        foreach (mv[i]) begin mv[i] = 0; mp[i] = 0; md[i] = 0; ms[i] = 0; mt[i] = 0; end
        foreach (mblk[t]) begin mblk[t] = 0; mbseq[t] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        step("R12 reset");
        // R2: fill the table in index order, then refuse.
        do_alloc(0, 10, 1, 1, 0); step("R2 a0");
        do_alloc(0, 11, 0, 2, 1); step("R2 a1");
        do_alloc(1, 20, 2, 3, 1); step("R2 a2");
        do_alloc(1, 21, 3, 0, 0); step("R2 a3");
        do_alloc(0, 30, 0, 0, 0); step("R2 full");
        // R1: hit and near-miss on schedule index.
        do_lkp(0, 11, 0, 0); step("R1 hit");
        do_lkp(0, 11, 1, 0); step("R1 miss");
        // R9: completion and ignored response.
        rsp_valid = 1; rsp_slot = 1; step("R9 ok");
        rsp_valid = 1; rsp_slot = 0; step("R9 nopend");
        do_lkp(0, 11, 0, 0); step("R9 done");
        // R3: fault on slot 3, then blocked allocation; R11 retire slot 0.
        flt_valid = 1; flt_slot = 3; step("R3 fault");
        do_alloc(1, 40, 0, 0, 0); do_lkp(0, 10, 1, 1); step("R3 refuse R11");
        do_alloc(0, 12, 1, 1, 0); step("R11 reuse");
        // R4: trap clears; fault again.
        trap_valid = 1; trap_tid = 1; step("R4 trap");
        flt_valid = 1; flt_slot = 3; step("R3 refault");
        // R5/R6: boundary equal to seq does not kill or release.
        do_sq(1, 21, 0); step("R5 equal");
        // R8/R6: stall squash, boundary 20 kills seq 21 stalled slot.
        do_sq(1, 19, 1); step("R8 sq");
        do_lkp(1, 21, 3, 0); step("R8 kept");
        step("R8 freed");
        // R7: squash pending slot 2, then response is dropped.
        do_sq(1, 19, 0); step("R7 sq");
        do_lkp(1, 20, 2, 0); step("R7 kept");
        rsp_valid = 1; rsp_slot = 2; step("R7 drop");
        // R10: block thread 0 on slot 0, squash and allocate together.
        flt_valid = 1; flt_slot = 0; step("R10 fault");
        do_sq(0, 11, 0); do_alloc(0, 13, 5, 2, 1); step("R10 same");
        do_lkp(0, 13, 5, 0); step("R10 survives");
        step("R10 settle");
        // Mixed random phase.
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 1)) do_alloc($urandom_range(0, 1), $urandom_range(0, 15),
                                              $urandom_range(0, 1), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
            do_lkp($urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 1), 1'($urandom_range(0, 3) == 0));
            if ($urandom_range(0, 2) == 0) begin rsp_valid = 1; rsp_slot = 2'($urandom_range(0, 3)); end
            if ($urandom_range(0, 5) == 0) begin flt_valid = 1; flt_slot = 2'($urandom_range(0, 3)); end
            if ($urandom_range(0, 7) == 0) begin trap_valid = 1; trap_tid = 1'($urandom_range(0, 1)); end
            if ($urandom_range(0, 5) == 0) do_sq($urandom_range(0, 1), $urandom_range(0, 15), 1'($urandom_range(0, 1)));
            step("R5 mix");
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule